// File: doc/BRIEF.md
# Configurable Audio Serial Transmitter

This block turns a stream of parallel audio samples into a two-slot serial audio line and acts as clock master for that line. It makes a bit clock from the system clock and drives a word-select line and a serial data line. The data changes on the falling bit-clock edge, so a receiver can sample on the rising edge. Samples arrive through a valid/ready handshake and wait in a two-entry stager until a frame starts.

One frame engine handles four frame formats. Each format is defined by the shape of word select and by whether the data lags that shape by one bit. The engine also handles mono and stereo operation with a per-slot enable mask. A disabled slot carries zeros, and in mono mode one sample can go into both slots. If a frame starts without enough staged samples, the frame is sent as silence and a sticky flag records the shortfall. Every configuration input, the clock divider included, is latched only when a frame starts.

Top module: `aud_serial_tx`

## Requirements
- R1: While reset is asserted, bclk_o, ws_o, sd_o and underrun_o are low and s_ready_o is high.
- R2: Each bit-clock half period lasts max(cfg_div_i,1) system clocks, and the bit clock starts low. ws_o and sd_o change only in the cycle in which bclk_o falls. A frame starts on the first fall after reset and then on the fall after the last bit of each frame.
- R3: cfg_fmt_i=0 is the standard two-slot format. Before polarity is applied, word select is low for the whole left (first) slot and high for the whole right slot. Data lags by one bit, so each slot's MSB appears one bit after the slot begins.
- R4: cfg_fmt_i=1 is left-justified. Its word select is the same as with code 0, and the MSB appears in the same bit as the slot's first word-select level.
- R5: cfg_fmt_i=2 is short pulse. Before polarity is applied, word select is high only for the first bit of the frame. Data lags by one bit.
- R6: cfg_fmt_i=3 is long pulse. Before polarity is applied, word select is high for the first data-width bits of the frame. Data lags by one bit.
- R7: cfg_dwidth_i codes 0,1,2,3 select 8,16,24,32 data bits, taken from the low bits of s_data_i and sent MSB first. cfg_swidth_i code 0 makes the slot as wide as the data, and codes 1,2,3 select 16,24,32 bits. The slot width used is the larger of the data width and the selected slot width, and the bits after the data are sent as zeros.
- R8: cfg_ws_inv_i=1 inverts ws_o for every format.
- R9: In cfg_mask_i, bit 0 enables the left slot and bit 1 enables the right slot. In stereo (cfg_mono_i=0) each frame takes two samples: the first goes to the left slot and the second to the right slot. A disabled slot sends zeros. Mask 2'b00 takes no samples and sends zeros.
- R10: In mono (cfg_mono_i=1) each frame takes one sample and sends it in every enabled slot, which means both slots when the mask is 2'b11. A disabled slot sends zeros.
- R11: If fewer samples are staged at a frame start than the frame needs, both slots send zeros and no sample is taken. underrun_o then goes high and stays high until reset.
- R12: Changes to the configuration inputs, cfg_div_i included, take effect only at the next frame start.
- R13: The stager holds up to two samples. s_ready_o is high whenever it holds fewer than two, and a sample is accepted on a clock where s_valid_i and s_ready_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_div_i | input | DIV_W | Half period of the bit clock, in system clocks (0 is treated as 1) |
| cfg_fmt_i | input | 2 | Frame format code |
| cfg_dwidth_i | input | 2 | Data width code |
| cfg_swidth_i | input | 2 | Slot width code (0 = same as data) |
| cfg_ws_inv_i | input | 1 | Invert word select |
| cfg_mono_i | input | 1 | Mono mode when high |
| cfg_mask_i | input | 2 | Slot enables: bit 0 left, bit 1 right |
| s_valid_i | input | 1 | Sample valid |
| s_data_i | input | 32 | Sample, right-justified |
| s_ready_o | output | 1 | Stager can accept a sample |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky flag for a frame sent without enough samples |

## Verification
The bench builds the block with DIV_W = 4 and uses divider values 0 through 3. With such short bit periods, even a 64-bit frame finishes within a few hundred system clocks, so every format, width, mask and mono/stereo combination can run for many frames. The configuration changes while a frame is in progress, which exercises the frame-boundary latch, the carry of the lagged bit from one frame into the next, and the switch of divider between frames. The feed is sometimes throttled and sometimes stopped, which reaches both a full stager and a shortfall.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  localparam int unsigned SAMPLE_W = 32;
  localparam int unsigned STAGE_DEPTH = 2;
  localparam int unsigned CNT_W = $clog2(STAGE_DEPTH + 1);

  typedef enum logic [1:0] {
    FMT_STD       = 2'd0,
    FMT_LEFTJ     = 2'd1,
    FMT_PCM_SHORT = 2'd2,
    FMT_PCM_LONG  = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [1:0] dw_sel;
    logic [1:0] sw_sel;
    logic       ws_inv;
    logic       mono;
    logic [1:0] mask;
  } frame_cfg_t;

  // code 0..3 -> 8,16,24,32
  function automatic logic [5:0] data_bits(input logic [1:0] sel);
    return {1'b0, sel, 3'b000} + 6'd8;
  endfunction

  function automatic logic [5:0] slot_bits(input frame_cfg_t c);
    logic [5:0] d;
    logic [5:0] s;
    d = data_bits(c.dw_sel);
    s = (c.sw_sel == 2'd0) ? d : data_bits(c.sw_sel);
    return (s > d) ? s : d;
  endfunction

endpackage

// File: rtl/aud_tx_bclk_gen.sv
module aud_tx_bclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] hc_q;
  logic [DIV_W-1:0] half_m1;
  logic             bclk_q;
  logic             wrap;

  assign half_m1 = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign wrap    = (hc_q >= half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q   <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      hc_q   <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      hc_q   <= hc_q + DIV_W'(1);
    end
  end

  assign bclk_o = bclk_q;
  assign fall_o = wrap & bclk_q;

endmodule

// File: rtl/aud_tx_stager.sv
module aud_tx_stager import aud_tx_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                s_valid_i,
  input  logic [SAMPLE_W-1:0] s_data_i,
  output logic                s_ready_o,
  input  logic [CNT_W-1:0]    pop_i,
  output logic [SAMPLE_W-1:0] head0_o,
  output logic [SAMPLE_W-1:0] head1_o,
  output logic [CNT_W-1:0]    cnt_o
);

  logic [STAGE_DEPTH-1:0][SAMPLE_W-1:0] ent_q, ent_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, rem;
  logic             push;

  assign s_ready_o = (cnt_q < CNT_W'(STAGE_DEPTH));
  assign push      = s_valid_i & s_ready_o;

  always_comb begin
    ent_d = ent_q;
    if (pop_i == CNT_W'(1)) ent_d[0] = ent_q[1];
    rem   = cnt_q - pop_i;
    cnt_d = rem;
    if (push) begin
      ent_d[rem[0]] = s_data_i;
      cnt_d         = rem + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      cnt_q <= '0;
    end else begin
      ent_q <= ent_d;
      cnt_q <= cnt_d;
    end
  end

  assign head0_o = ent_q[0];
  assign head1_o = ent_q[1];
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/aud_tx_frame_engine.sv
module aud_tx_frame_engine import aud_tx_pkg::*; #(
  parameter int unsigned DIV_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fall_i,
  input  frame_cfg_t          cfg_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [SAMPLE_W-1:0] head0_i,
  input  logic [SAMPLE_W-1:0] head1_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [CNT_W-1:0]    pop_o,
  output logic [DIV_W-1:0]    div_eff_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                underrun_o
);

  frame_cfg_t          cfg_q, cfg_n;
  logic [DIV_W-1:0]    div_q;
  logic                started_q;
  logic [5:0]          pos_q, pos_n, last_pos, slot_n, dbits_n, idx;
  logic [SAMPLE_W-1:0] left_q, right_q, left_n, right_n, samp;
  logic                prev_q, ws_q, sd_q, urun_q;
  logic                frame_start, have, in_right, bit_u, ws_raw, lag;
  logic [CNT_W-1:0]    need;

  assign last_pos    = 6'({slot_bits(cfg_q), 1'b0} - 7'd1);
  assign frame_start = fall_i & (~started_q | (pos_q == last_pos));
  assign cfg_n       = frame_start ? cfg_i : cfg_q;

  // samples a frame needs under the incoming configuration
  always_comb begin
    if (cfg_n.mask == 2'b00) need = CNT_W'(0);
    else if (cfg_n.mono)     need = CNT_W'(1);
    else                     need = CNT_W'(2);
  end

  assign have  = (cnt_i >= need);
  assign pop_o = (frame_start & have) ? need : CNT_W'(0);

  always_comb begin
    left_n  = left_q;
    right_n = right_q;
    if (frame_start) begin
      if (!have) begin
        left_n  = '0;
        right_n = '0;
      end else if (cfg_n.mono) begin
        left_n  = cfg_n.mask[0] ? head0_i : '0;
        right_n = cfg_n.mask[1] ? head0_i : '0;
      end else begin
        left_n  = cfg_n.mask[0] ? head0_i : '0;
        right_n = cfg_n.mask[1] ? head1_i : '0;
      end
    end
  end

  assign pos_n    = frame_start ? 6'd0 : pos_q + 6'd1;
  assign slot_n   = slot_bits(cfg_n);
  assign dbits_n  = data_bits(cfg_n.dw_sel);
  assign in_right = (pos_n >= slot_n);
  assign idx      = in_right ? pos_n - slot_n : pos_n;
  assign samp     = in_right ? right_n : left_n;
  assign bit_u    = (idx < dbits_n) ? samp[5'(dbits_n - 6'd1 - idx)] : 1'b0;

  always_comb begin
    unique case (cfg_n.fmt)
      FMT_STD, FMT_LEFTJ: ws_raw = in_right;
      FMT_PCM_SHORT:      ws_raw = (pos_n == 6'd0);
      default:            ws_raw = (pos_n < dbits_n);
    endcase
  end

  assign lag = (cfg_n.fmt != FMT_LEFTJ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      div_q     <= '0;
      started_q <= 1'b0;
      pos_q     <= '0;
      left_q    <= '0;
      right_q   <= '0;
      prev_q    <= 1'b0;
      ws_q      <= 1'b0;
      sd_q      <= 1'b0;
      urun_q    <= 1'b0;
    end else if (fall_i) begin
      cfg_q   <= cfg_n;
      pos_q   <= pos_n;
      left_q  <= left_n;
      right_q <= right_n;
      prev_q  <= bit_u;
      ws_q    <= ws_raw ^ cfg_n.ws_inv;
      sd_q    <= lag ? prev_q : bit_u;
      if (frame_start) begin
        div_q     <= div_i;
        started_q <= 1'b1;
        if (!have) urun_q <= 1'b1;
      end
    end
  end

  assign div_eff_o  = started_q ? div_q : div_i;
  assign ws_o       = ws_q;
  assign sd_o       = sd_q;
  assign underrun_o = urun_q;

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx import aud_tx_pkg::*; #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [1:0]       cfg_fmt_i,
  input  logic [1:0]       cfg_dwidth_i,
  input  logic [1:0]       cfg_swidth_i,
  input  logic             cfg_ws_inv_i,
  input  logic             cfg_mono_i,
  input  logic [1:0]       cfg_mask_i,
  input  logic             s_valid_i,
  input  logic [31:0]      s_data_i,
  output logic             s_ready_o,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             sd_o,
  output logic             underrun_o
);

  frame_cfg_t          cfg_w;
  logic [DIV_W-1:0]    div_eff_w;
  logic                fall_w;
  logic [CNT_W-1:0]    pop_w, cnt_w;
  logic [SAMPLE_W-1:0] head0_w, head1_w;

  assign cfg_w = '{fmt:    fmt_e'(cfg_fmt_i),
                   dw_sel: cfg_dwidth_i,
                   sw_sel: cfg_swidth_i,
                   ws_inv: cfg_ws_inv_i,
                   mono:   cfg_mono_i,
                   mask:   cfg_mask_i};

  aud_tx_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_eff_w),
    .bclk_o (bclk_o),
    .fall_o (fall_w)
  );

  aud_tx_stager u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s_valid_i (s_valid_i),
    .s_data_i  (s_data_i),
    .s_ready_o (s_ready_o),
    .pop_i     (pop_w),
    .head0_o   (head0_w),
    .head1_o   (head1_w),
    .cnt_o     (cnt_w)
  );

  aud_tx_frame_engine #(.DIV_W(DIV_W)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall_w),
    .cfg_i      (cfg_w),
    .div_i      (cfg_div_i),
    .head0_i    (head0_w),
    .head1_i    (head1_w),
    .cnt_i      (cnt_w),
    .pop_o      (pop_w),
    .div_eff_o  (div_eff_w),
    .ws_o       (ws_o),
    .sd_o       (sd_o),
    .underrun_o (underrun_o)
  );

endmodule

// File: rtl/aud_tx_checker.sv
module aud_tx_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bclk_o,
  input logic       ws_o,
  input logic       sd_o,
  input logic       underrun_o,
  input logic [1:0] cfg_mask_i,
  input logic [1:0] pop_i,
  input logic [1:0] cnt_i
);

  assert_ws_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> $fell(bclk_o));

  assert_sd_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> $fell(bclk_o));

  assert_underrun_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);

  assert_pop_within_stage_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i <= cnt_i);

  assert_no_pop_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mask_i == 2'b00) |-> (pop_i == 2'd0));

endmodule

bind aud_serial_tx aud_tx_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bclk_o     (bclk_o),
  .ws_o       (ws_o),
  .sd_o       (sd_o),
  .underrun_o (underrun_o),
  .cfg_mask_i (cfg_mask_i),
  .pop_i      (pop_w),
  .cnt_i      (cnt_w)
);

// File: tb/aud_serial_tx_test.sv
module aud_serial_tx_test;

  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_div;
  logic [1:0]       cfg_fmt, cfg_dw, cfg_sw, cfg_mask;
  logic             cfg_inv, cfg_mono;
  logic             s_valid = 1'b0;
  logic [31:0]      s_data = '0;
  logic             s_ready, bclk, ws, sd, urun;

  always #5 clk = ~clk;

  aud_serial_tx #(.DIV_W(DIV_W)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_div_i    (cfg_div),
    .cfg_fmt_i    (cfg_fmt),
    .cfg_dwidth_i (cfg_dw),
    .cfg_swidth_i (cfg_sw),
    .cfg_ws_inv_i (cfg_inv),
    .cfg_mono_i   (cfg_mono),
    .cfg_mask_i   (cfg_mask),
    .s_valid_i    (s_valid),
    .s_data_i     (s_data),
    .s_ready_o    (s_ready),
    .bclk_o       (bclk),
    .ws_o         (ws),
    .sd_o         (sd),
    .underrun_o   (urun)
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    feed_en = 1'b0, gap_mode = 1'b0, gap_tog = 1'b0;
  logic [31:0] next_val = 32'h1234_5678;

  // reference model state
  logic [31:0] st_q[$];
  int          m_hc, m_pos, m_div, half, need, s_w, d_w, idx;
  bit          m_bclk, m_started, m_prev, m_ws, m_sd, m_urun;
  bit          fall, fs, push_ok, u, wr, lagged;
  logic [1:0]  m_fmt, m_dw, m_sw, m_mask;
  bit          m_inv, m_mono;
  logic [31:0] m_l, m_r, a, b, smp;

  function automatic int dbits(logic [1:0] sel);
    return 8 * int'(sel) + 8;
  endfunction

  function automatic int sbits(logic [1:0] dsel, logic [1:0] ssel);
    int d, s;
    d = dbits(dsel);
    s = (ssel == 2'd0) ? d : dbits(ssel);
    return (s > d) ? s : d;
  endfunction

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hc = 0; m_bclk = 0; m_started = 0; m_pos = 0; m_div = 0;
      m_prev = 0; m_ws = 0; m_sd = 0; m_urun = 0; m_l = 0; m_r = 0;
      m_fmt = 0; m_dw = 0; m_sw = 0; m_mask = 0; m_inv = 0; m_mono = 0;
      st_q.delete();
    end else begin
      half = m_started ? m_div : int'(cfg_div);
      if (half == 0) half = 1;
      fall = 0;
      if (m_hc >= half - 1) begin
        m_hc = 0;
        fall = m_bclk;
        m_bclk = !m_bclk;
      end else m_hc++;
      push_ok = (st_q.size() < 2);
      if (fall) begin
        fs = !m_started || (m_pos == 2 * sbits(m_dw, m_sw) - 1);
        if (fs) begin
          m_fmt = cfg_fmt; m_dw = cfg_dw; m_sw = cfg_sw; m_inv = cfg_inv;
          m_mono = cfg_mono; m_mask = cfg_mask; m_div = int'(cfg_div);
          m_started = 1; m_pos = 0;
          need = (m_mask == 2'b00) ? 0 : (m_mono ? 1 : 2);
          if (st_q.size() < need) begin
            m_urun = 1; m_l = 0; m_r = 0;
          end else begin
            a = (need >= 1) ? st_q.pop_front() : 32'h0;
            b = (need == 2) ? st_q.pop_front() : 32'h0;
            m_l = m_mask[0] ? a : 32'h0;
            m_r = m_mask[1] ? (m_mono ? a : b) : 32'h0;
          end
        end else m_pos++;
        s_w = sbits(m_dw, m_sw);
        d_w = dbits(m_dw);
        wr  = (m_pos >= s_w);
        idx = wr ? m_pos - s_w : m_pos;
        smp = wr ? m_r : m_l;
        u   = (idx < d_w) ? smp[d_w - 1 - idx] : 1'b0;
        case (m_fmt)
          2'd0, 2'd1: m_ws = wr;
          2'd2:       m_ws = (m_pos == 0);
          default:    m_ws = (m_pos < d_w);
        endcase
        m_ws = m_ws ^ m_inv;
        lagged = (m_fmt != 2'd1);
        m_sd = lagged ? m_prev : u;
        m_prev = u;
      end
      if (s_valid && push_ok) begin
        st_q.push_back(s_data);
        next_val = next_val * 32'd1664525 + 32'd1013904223;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("bclk_o", {31'b0, bclk}, {31'b0, m_bclk});
      chk("ws_o", {31'b0, ws}, {31'b0, m_ws});
      chk("sd_o", {31'b0, sd}, {31'b0, m_sd});
      chk("underrun_o", {31'b0, urun}, {31'b0, m_urun});
      chk("s_ready_o", {31'b0, s_ready}, {31'b0, st_q.size() < 2});
    end
    gap_tog = !gap_tog;
    s_valid = feed_en && (!gap_mode || gap_tog);
    s_data  = next_val;
  end

  task automatic set_cfg(int div, int fmt, int dw, int sw, bit inv, bit mono, int mask);
    @(negedge clk);
    cfg_div = DIV_W'(div); cfg_fmt = 2'(fmt); cfg_dw = 2'(dw); cfg_sw = 2'(sw);
    cfg_inv = inv; cfg_mono = mono; cfg_mask = 2'(mask);
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk); @(negedge clk); #1 rst_n = 1'b1;
  endtask

  initial begin
    cfg_div = 2; cfg_fmt = 0; cfg_dw = 1; cfg_sw = 0; cfg_inv = 0; cfg_mono = 0; cfg_mask = 3;
    feed_en = 1'b1;
    run(3);
    cur_req = "R1";
    chk("bclk_o reset", {31'b0, bclk}, 32'd0);
    chk("ws_o reset", {31'b0, ws}, 32'd0);
    chk("sd_o reset", {31'b0, sd}, 32'd0);
    chk("underrun_o reset", {31'b0, urun}, 32'd0);
    chk("s_ready_o reset", {31'b0, s_ready}, 32'd1);
    #1 rst_n = 1'b1;

    cur_req = "R3 R2 R13";          run(2000);
    cur_req = "R4 R7 R12";          set_cfg(1, 1, 0, 2, 0, 0, 3); run(2000);
    cur_req = "R5 R9";              set_cfg(3, 2, 2, 0, 0, 0, 1); gap_mode = 1; run(3000);
    cur_req = "R6 R10 R8";          set_cfg(0, 3, 3, 0, 1, 1, 3); gap_mode = 0; run(2000);
    cur_req = "R10 R7";             set_cfg(1, 0, 0, 3, 0, 1, 2); run(2000);
    cur_req = "R9 R8";              set_cfg(2, 1, 1, 1, 1, 0, 2); run(2000);
    cur_req = "R12 R2";             set_cfg(3, 3, 1, 2, 0, 0, 3); run(37);
                                    set_cfg(1, 2, 3, 0, 1, 1, 1); run(1500);

    cur_req = "R9";
    set_cfg(1, 0, 1, 0, 0, 0, 0);
    pulse_reset();
    feed_en = 1'b0;
    run(800);
    chk("underrun_o with mask 00 and no feed", {31'b0, urun}, 32'd0);

    cur_req = "R11";
    feed_en = 1'b1;
    set_cfg(1, 0, 1, 0, 0, 1, 1);
    pulse_reset();
    run(400);
    chk("underrun_o while fed", {31'b0, urun}, 32'd0);
    feed_en = 1'b0;
    run(600);
    chk("underrun_o after starving", {31'b0, urun}, 32'd1);
    feed_en = 1'b1;
    run(400);
    chk("underrun_o stays set", {31'b0, urun}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule